// File: doc/BRIEF.md
# Register Write-Protection Key Unlock

This block guards a bank of configuration registers. Software must write a two-byte key to a dedicated key register before any of those registers accept a write. The block sits on a simple register bus with one write strobe, one address bus, one write data bus and a combinational read data bus. It watches that bus and keeps a small lock state machine. It drives a write-enable qualifier that the protected registers AND into their own write strobes.

The key is 0xCA followed by 0x53, counted over writes to the key register only. Writes to any other address may fall between the two key bytes and do not disturb the sequence. Any other byte written to the key register puts the bank back under protection at once and discards a half-entered key; 0xFF is the usual relock value. A status word at its own address reports the lock state.

Top module: `keyguard`

## Requirements
- R1: After reset the bank is locked: the status bit reads 1 and `prot_wr_en` stays 0 for writes to plain addresses.
- R2: A key-register write with low byte 0xCA, followed by the next key-register write with low byte 0x53, unlocks the bank from the cycle after the second write.
- R3: A 0x53 key write whose preceding key-register write was not 0xCA leaves the bank locked.
- R4: A key write with a low byte that is neither 0xCA nor a 0x53 completing a sequence locks the bank and discards any partial progress, so a later lone 0x53 does not unlock.
- R5: While unlocked, any key-register write relocks the bank in the next cycle; 0xFF and 0x53 simply relock, and 0xCA relocks and also counts as the first byte of a new sequence.
- R6: Writes to any address other than the key register, including the status address, never change the lock state or break a sequence in progress.
- R7: `prot_wr_en` is 1 exactly in a cycle with `bus_wr` high, an address that is neither the key nor the status address, and the bank unlocked at that cycle's start.
- R8: Reading the status address returns bit 0 = 1 when locked and 0 when unlocked, with all other bits 0. The key register and every other address read as 0. The read is combinational on `bus_addr`.
- R9: Only bits [7:0] of `bus_wdata` take part in key matching; the upper bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | ADDR_W | Register address (key at KEY_ADDR, default 0x24; status at STAT_ADDR, default 0x0C) |
| bus_wdata | input | DATA_W | Write data; key byte in bits [7:0] |
| bus_rdata | output | DATA_W | Combinational read data for `bus_addr` |
| prot_wr_en | output | 1 | Write qualifier for the protected registers |
| bank_open | output | 1 | Level: 1 while the bank is unlocked |

## Verification
The qualifier and the read data are combinational. Each is checked in the same cycle as the bus access, against the lock state that held when that cycle began. A key write changes the state at the closing edge of its cycle, so its effect is first seen by the next access one cycle later. The driver applies one access per cycle at the falling edge and pushes the value it expects for that cycle. The monitor compares that value a quarter period later, before the rising edge that would change the state. The expected state comes from the bench's own model of the key sequence, updated only after each expectation has been queued.

// File: rtl/keyguard_pkg.sv
package keyguard_pkg;

  typedef enum logic [1:0] {
    KG_LOCKED = 2'd0,
    KG_ARMED  = 2'd1,
    KG_OPEN   = 2'd2
  } kg_state_e;

  // Next lock state after one write to the key register.
  function automatic kg_state_e kg_next(kg_state_e cur, logic [7:0] b,
                                        logic [7:0] k1, logic [7:0] k2);
    kg_state_e n;
    if (b == k1)                          n = KG_ARMED;
    else if (cur == KG_ARMED && b == k2)  n = KG_OPEN;
    else                                  n = KG_LOCKED;
    return n;
  endfunction

  // Status word: bit 0 set while locked.
  function automatic logic kg_locked_bit(logic open);
    return ~open;
  endfunction

endpackage

// File: rtl/keyguard_decode.sv
module keyguard_decode #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] KEY_ADDR  = 'h24,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 'h0C
) (
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              key_wr,
  output logic              stat_sel,
  output logic              plain_wr,
  output logic [7:0]        key_byte
);
  logic key_sel;

  assign key_sel  = (bus_addr == KEY_ADDR);
  assign stat_sel = (bus_addr == STAT_ADDR);
  assign key_wr   = bus_wr & key_sel;
  assign plain_wr = bus_wr & ~key_sel & ~stat_sel;
  assign key_byte = bus_wdata[7:0];

  generate
    if (DATA_W > 8) begin : g_hi
      logic unused_hi;
      assign unused_hi = ^bus_wdata[DATA_W-1:8];
    end
  endgenerate
endmodule

// File: rtl/keyguard_fsm.sv
module keyguard_fsm
  import keyguard_pkg::*;
#(
  parameter logic [7:0] KEY_FIRST  = 8'hCA,
  parameter logic [7:0] KEY_SECOND = 8'h53
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       key_wr,
  input  logic [7:0] key_byte,
  output logic       armed,
  output logic       unlocked
);
  kg_state_e state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      state_q <= KG_LOCKED;
    else if (key_wr) state_q <= kg_next(state_q, key_byte, KEY_FIRST, KEY_SECOND);
  end

  assign armed    = (state_q == KG_ARMED);
  assign unlocked = (state_q == KG_OPEN);
endmodule

// File: rtl/keyguard_rdmux.sv
module keyguard_rdmux
  import keyguard_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              stat_sel,
  input  logic              unlocked,
  output logic [DATA_W-1:0] rdata
);
  always_comb begin
    rdata    = '0;
    rdata[0] = stat_sel & kg_locked_bit(unlocked);
  end
endmodule

// File: rtl/keyguard.sv
module keyguard #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] KEY_ADDR  = 'h24,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 'h0C,
  parameter logic [7:0] KEY_FIRST  = 8'hCA,
  parameter logic [7:0] KEY_SECOND = 8'h53
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              prot_wr_en,
  output logic              bank_open
);
  logic       key_wr;
  logic       stat_sel;
  logic       plain_wr;
  logic [7:0] key_byte;
  logic       armed;

  keyguard_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .KEY_ADDR(KEY_ADDR), .STAT_ADDR(STAT_ADDR)
  ) u_decode (
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .key_wr(key_wr), .stat_sel(stat_sel), .plain_wr(plain_wr),
    .key_byte(key_byte)
  );

  keyguard_fsm #(
    .KEY_FIRST(KEY_FIRST), .KEY_SECOND(KEY_SECOND)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .key_wr(key_wr), .key_byte(key_byte),
    .armed(armed), .unlocked(bank_open)
  );

  keyguard_rdmux #(.DATA_W(DATA_W)) u_rdmux (
    .stat_sel(stat_sel), .unlocked(bank_open), .rdata(bus_rdata)
  );

  assign prot_wr_en = plain_wr & bank_open;
endmodule

// File: rtl/keyguard_chk.sv
module keyguard_chk #(
  parameter logic [7:0] KEY_FIRST  = 8'hCA,
  parameter logic [7:0] KEY_SECOND = 8'h53
) (
  input logic       clk,
  input logic       rst_n,
  input logic       key_wr,
  input logic [7:0] key_byte,
  input logic       armed,
  input logic       unlocked,
  input logic       plain_wr,
  input logic       stat_sel,
  input logic       prot_wr_en,
  input logic       rdata0
);
  AST_RESET_LOCKED: assert property (@(posedge clk)
    !rst_n |=> !unlocked); // R1

  AST_OPEN_FROM_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked) |-> ($past(key_wr) && $past(armed) && $past(key_byte) == KEY_SECOND)); // R2

  AST_NO_OPEN_UNARMED: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr && !armed) |=> !unlocked); // R3

  AST_BAD_KEY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr && key_byte != KEY_FIRST && !(armed && key_byte == KEY_SECOND))
      |=> (!unlocked && !armed)); // R4

  AST_FIRST_REARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr && key_byte == KEY_FIRST) |=> (armed && !unlocked)); // R5

  AST_OTHER_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !key_wr |=> ($stable(unlocked) && $stable(armed))); // R6

  AST_QUAL_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    prot_wr_en |-> (unlocked && plain_wr)); // R7

  AST_STATUS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    stat_sel |-> (rdata0 == !unlocked)); // R8
endmodule

bind keyguard keyguard_chk #(
  .KEY_FIRST(KEY_FIRST), .KEY_SECOND(KEY_SECOND)
) u_chk (
  .clk(clk), .rst_n(rst_n), .key_wr(key_wr), .key_byte(key_byte),
  .armed(armed), .unlocked(bank_open), .plain_wr(plain_wr),
  .stat_sel(stat_sel), .prot_wr_en(prot_wr_en), .rdata0(bus_rdata[0])
);

// File: tb/keyguard_bench.sv
module keyguard_bench;
  localparam logic [7:0] KA = 8'h24;
  localparam logic [7:0] SA = 8'h0C;
  localparam logic [7:0] PA = 8'h40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        prot_wr_en;
  logic        bank_open;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    string       tag;
    logic [31:0] exp_rd;
    logic        exp_q;
  } item_t;
  item_t sb[$];

  bit m_open = 1'b0;
  bit m_armed = 1'b0;

  always #2 clk = ~clk;

  keyguard u_keyguard (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .prot_wr_en(prot_wr_en), .bank_open(bank_open)
  );

  function automatic logic [31:0] exp_read(logic [7:0] a);
    return (a == SA) ? {31'd0, ~m_open} : 32'd0;
  endfunction

  task automatic op(input bit wr, input logic [7:0] a, input logic [31:0] d, input string tag);
    item_t it;
    @(negedge clk);
    bus_wr = wr; bus_addr = a; bus_wdata = d;
    it.tag = tag;
    it.exp_rd = exp_read(a);
    it.exp_q = wr && a != KA && a != SA && m_open;
    sb.push_back(it);
    if (wr && a == KA) begin
      if (d[7:0] == 8'hCA) begin m_armed = 1'b1; m_open = 1'b0; end
      else if (m_armed && d[7:0] == 8'h53) begin m_armed = 1'b0; m_open = 1'b1; end
      else begin m_armed = 1'b0; m_open = 1'b0; end
    end
  endtask

  task automatic idle();
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = PA; bus_wdata = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // Monitor: compares each queued expectation before the next rising edge.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        checks++;
        if (bus_rdata !== it.exp_rd) begin
          failures++;
          $display("FAIL %s rdata actual=%h expected=%h", it.tag, bus_rdata, it.exp_rd);
        end
        checks++;
        if (prot_wr_en !== it.exp_q) begin
          failures++;
          $display("FAIL %s prot_wr_en actual=%b expected=%b", it.tag, prot_wr_en, it.exp_q);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    op(0, SA, 0, "R1 status after reset");
    op(1, PA, 32'h1234, "R1 plain write locked");
    // R2: proper sequence
    op(1, KA, 32'hCA, "R2 first key");
    op(1, KA, 32'h53, "R2 second key");
    op(0, SA, 0, "R2 status open");
    op(1, PA, 32'h55, "R7 plain write open");
    op(1, SA, 32'h1, "R7 status write no qualifier");
    op(1, KA, 32'h0, "R7 key write no qualifier");
    // R5: relock with 0xFF
    op(1, KA, 32'hCA, "R2 rekey first");
    op(1, KA, 32'h53, "R2 rekey second");
    op(1, KA, 32'hFF, "R5 relock FF");
    op(0, SA, 0, "R5 status after FF");
    op(1, PA, 32'h9, "R5 plain write after FF");
    // R3: lone second key
    op(1, KA, 32'h53, "R3 lone second key");
    op(0, SA, 0, "R3 status after lone second");
    op(1, KA, 32'h53, "R3 repeated second key");
    op(0, SA, 0, "R3 status still locked");
    // R4: wrong byte in the middle
    op(1, KA, 32'hCA, "R4 first key");
    op(1, KA, 32'h11, "R4 wrong byte");
    op(1, KA, 32'h53, "R4 second after wrong");
    op(0, SA, 0, "R4 status locked");
    op(1, PA, 32'h7, "R4 plain write locked");
    // R6: other writes between keys
    op(1, KA, 32'hCA, "R6 first key");
    op(1, PA, 32'h3, "R6 plain write between");
    op(1, SA, 32'hFF, "R6 status write between");
    op(0, KA, 0, "R8 key register reads zero");
    op(1, KA, 32'h53, "R6 second key");
    op(0, SA, 0, "R6 status open");
    op(0, PA, 0, "R8 other address reads zero");
    // R5: 0xCA while open relocks and arms
    op(1, KA, 32'hCA, "R5 first key while open");
    op(0, SA, 0, "R5 status relocked by first");
    op(1, KA, 32'h53, "R5 second completes new sequence");
    op(0, SA, 0, "R5 status open again");
    op(1, KA, 32'h53, "R5 second key while open relocks");
    op(0, SA, 0, "R5 status after second while open");
    // R9: upper data bits ignored
    op(1, KA, 32'hABCD_01CA, "R9 first key with upper bits");
    op(1, KA, 32'hFFFF_FF53, "R9 second key with upper bits");
    op(0, SA, 0, "R9 status open");
    op(1, KA, 32'h0000_CA00, "R9 CA in upper byte relocks");
    op(0, SA, 0, "R9 status locked");
    op(1, KA, 32'h0000_0153, "R9 lone second with upper bits");
    op(1, PA, 32'h1, "R9 plain write locked");
    idle();
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule